// File: doc/BRIEF.md
# Multicycle 16-bit Mini Processor

A compact processor core with eight 16-bit general registers and a program counter. It works through one word-addressed memory over a synchronous port. Each access drives an address, write data, a strobe that marks the access as valid, and a select that chooses read or write. The memory returns read data one cycle after it sees the address.

Each instruction is fetched in two cycles and then executed in one or two more. The instruction set covers register-indirect load and store, register move, register increment, load-immediate, an unconditional jump and a compare-and-jump. The last three take a second word that carries a 16-bit immediate.

The core has no halt. A program ends by jumping to itself, and the surrounding system inspects memory afterwards.

Top module: `mini_cpu16`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the core presents a read of address 0000H: strobe 1, select 0. Reset clears the program counter and all eight registers.
- R2: Instruction encoding: bits 15:11 hold the opcode, bits 5:3 name the first register and bits 2:0 name the second. Every read puts the strobe high for one cycle and takes the data in the following cycle. The cycle after any read makes no access.
- R3: Opcode 00001 (load) reads memory at the address held in the first register and writes the word to the second register.
- R4: Opcode 00010 (store) writes the first register to the address held in the second register. The select is high for exactly one cycle per store and only while the strobe is high, and the next cycle is a read.
- R5: Opcode 00011 (move) copies the first register into the second.
- R6: Opcode 00100 (load-immediate) writes the word that follows into the second register, and execution resumes after that word.
- R7: Opcode 00101 (jump) loads the program counter with the word that follows.
- R8: Opcode 00110 (compare-and-jump) jumps to the word that follows only when the first register is greater than the second, compared as unsigned numbers. When the two are equal or the first is smaller, execution resumes after the immediate word.
- R9: Opcode 00111 (increment) adds one to the second register, and FFFFH becomes 0000H.
- R10: Opcode 00000 and every opcode from 01000 to 11111 change no register and make no memory write, and execution continues at the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address of the current access |
| mem_wdata | output | 16 | Data for a write access |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| mem_valid | output | 1 | High while an access is made |
| mem_we | output | 1 | 1 selects write, 0 selects read |

## Verification
Two decisions land on the same clock edge in the cycle that returns the immediate word of a compare-and-jump: whether the branch is taken, and the advance of the program counter past the immediate. The bench sets up three operand pairs: equal values, a larger value that is positive as a signed number, and 8000H against a small value, which a signed compare would treat the wrong way. Code placed right after each branch writes a marker word into memory. Each outcome is then judged from memory contents: a marker that is present shows a branch wrongly not taken, and a missing or shifted result shows a wrong jump or a lost immediate.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_LD   = 5'd1,
        OP_ST   = 5'd2,
        OP_MV   = 5'd3,
        OP_LDI  = 5'd4,
        OP_JMP  = 5'd5,
        OP_BGT  = 5'd6,
        OP_INC  = 5'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,   // drive instruction read
        ST_FWAIT = 3'd1,   // capture instruction word
        ST_EXEC  = 3'd2,   // decode, act or issue second access
        ST_LWAIT = 3'd3,   // capture load data
        ST_IWAIT = 3'd4    // capture immediate word
    } state_e;

endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [SW-1:0] rd_a_sel,
    output logic [W-1:0]  rd_a,
    input  logic [SW-1:0] rd_b_sel,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_sel] <= wr_data;
        end
    end

    assign rd_a = regs_q[rd_a_sel];
    assign rd_b = regs_q[rd_b_sel];

endmodule

// File: rtl/mcpu_exu.sv
module mcpu_exu #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         a_above_b,
    output logic [W-1:0] b_next
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // unsigned magnitude compare, wrapping increment
    assign a_above_b = op_a > op_b;
    assign b_next    = op_b + ONE;

endmodule

// File: rtl/mini_cpu16.sv
module mini_cpu16 #(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_valid,
    output logic         mem_we
);
    import mcpu_pkg::*;

    localparam int SW  = $clog2(NREG);
    localparam int OPW = 5;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        state_e       st;
        logic [W-1:0] pc;
        logic [W-1:0] ir;
    } core_t;

    localparam core_t CORE_RST = '{st: ST_FETCH, pc: '0, ir: '0};

    core_t core_d, core_q;

    op_e           op;
    logic [SW-1:0] src_sel, dst_sel;
    logic [W-1:0]  src_val, dst_val, dst_inc;
    logic          src_above;
    logic          rf_we;
    logic [W-1:0]  rf_wdata;
    logic          unused_ir;

    assign op        = op_e'(core_q.ir[W-1 -: OPW]);
    assign src_sel   = core_q.ir[2*SW-1 -: SW];
    assign dst_sel   = core_q.ir[SW-1:0];
    assign unused_ir = ^core_q.ir[W-OPW-1:2*SW];

    mcpu_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .wr_sel   (dst_sel),
        .wr_data  (rf_wdata),
        .rd_a_sel (src_sel),
        .rd_a     (src_val),
        .rd_b_sel (dst_sel),
        .rd_b     (dst_val)
    );

    mcpu_exu #(.W(W)) u_exu (
        .op_a      (src_val),
        .op_b      (dst_val),
        .a_above_b (src_above),
        .b_next    (dst_inc)
    );

    always_comb begin
        core_d    = core_q;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = core_q.pc;
        mem_wdata = src_val;
        rf_we     = 1'b0;
        rf_wdata  = src_val;

        case (core_q.st)
            ST_FETCH: begin
                mem_valid = 1'b1;
                core_d.st = ST_FWAIT;
            end
            ST_FWAIT: begin
                core_d.ir = mem_rdata;
                core_d.pc = core_q.pc + ONE;
                core_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                core_d.st = ST_FETCH;
                case (op)
                    OP_LD: begin
                        mem_valid = 1'b1;
                        mem_addr  = src_val;
                        core_d.st = ST_LWAIT;
                    end
                    OP_ST: begin
                        mem_valid = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = dst_val;
                    end
                    OP_MV: begin
                        rf_we = 1'b1;
                    end
                    OP_INC: begin
                        rf_we    = 1'b1;
                        rf_wdata = dst_inc;
                    end
                    OP_LDI, OP_JMP, OP_BGT: begin
                        mem_valid = 1'b1;
                        core_d.st = ST_IWAIT;
                    end
                    default: ;
                endcase
            end
            ST_LWAIT: begin
                rf_we     = 1'b1;
                rf_wdata  = mem_rdata;
                core_d.st = ST_FETCH;
            end
            ST_IWAIT: begin
                core_d.st = ST_FETCH;
                core_d.pc = core_q.pc + ONE;
                case (op)
                    OP_LDI: begin
                        rf_we    = 1'b1;
                        rf_wdata = mem_rdata;
                    end
                    OP_JMP: core_d.pc = mem_rdata;
                    OP_BGT: if (src_above) core_d.pc = mem_rdata;
                    default: ;
                endcase
            end
            default: core_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= CORE_RST;
        else        core_q <= core_d;
    end

endmodule

// File: rtl/mini_cpu16_chk.sv
module mini_cpu16_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] mem_addr,
    input logic         mem_valid,
    input logic         mem_we
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r1_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (mem_valid && !mem_we && mem_addr == '0));

    a_r2_idle_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |=> !mem_valid);

    a_r4_write_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_valid);

    a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_valid && !mem_we));

endmodule

bind mini_cpu16 mini_cpu16_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .mem_we    (mem_we)
);

// File: tb/mini_cpu16_tb_top.sv
`timescale 1ns/100ps
module mini_cpu16_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_valid, mem_we;

    logic [15:0] mem [1024];
    int          wcnt;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2.5 clk = ~clk;

    mini_cpu16 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_valid (mem_valid),
        .mem_we    (mem_we)
    );

    // synchronous word memory: read data appears the cycle after the address
    always @(posedge clk) begin
        if (mem_valid) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
        if (rst_n && mem_valid && mem_we) wcnt <= wcnt + 1;
    end

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] val;
    } exp_t;

    localparam exp_t EXP [9] = '{
        '{16'h0100, 16'h1234},   // R4 store through R1
        '{16'h0101, 16'h1234},   // R5 moved copy
        '{16'h0102, 16'h0000},   // R9 FFFF wrapped
        '{16'h0103, 16'hBEEF},   // R3 loaded word
        '{16'h0104, 16'h0000},   // R10 undefined opcode left R7 alone
        '{16'h0105, 16'h0055},   // R6 immediate, pc past it
        '{16'h0106, 16'h8000},   // R8 unsigned taken, R7 jump target
        '{16'h0107, 16'h0000},   // R7 nothing beyond
        '{16'h0200, 16'hBEEF}    // R8 poison stores skipped
    };
    localparam string EXP_REQ [9] = '{"R4", "R5", "R9", "R3", "R10", "R6", "R8", "R7", "R8"};

    function automatic logic [15:0] enc(input int op, input int s, input int d);
        logic [4:0] o5 = op[4:0];
        logic [2:0] s3 = s[2:0];
        logic [2:0] d3 = d[2:0];
        return {o5, 5'b0, s3, d3};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] got,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    endtask

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    // hold reset, release at a falling edge, then probe the port before the next rising edge
    task automatic reset_and_probe(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        wcnt  = 0;
        repeat (3) @(negedge clk);
        check(mem_we == 1'b0, tag, {15'b0, mem_we}, 16'h0000);
        rst_n = 1'b1;
        #0.5;
        check(mem_valid && !mem_we && mem_addr == 16'h0000, tag, mem_addr, 16'h0000);
    endtask

    task automatic load_prog1();
        clear_mem();
        mem[0]  = enc(4,0,1); mem[1]  = 16'h0100;
        mem[2]  = enc(4,0,2); mem[3]  = 16'hFFFF;
        mem[4]  = enc(7,0,2);
        mem[5]  = enc(4,0,3); mem[6]  = 16'h1234;
        mem[7]  = enc(2,3,1);
        mem[8]  = enc(3,3,4);
        mem[9]  = enc(7,0,1);
        mem[10] = enc(2,4,1);
        mem[11] = enc(7,0,1);
        mem[12] = enc(2,2,1);
        mem[13] = enc(4,0,6); mem[14] = 16'h0200;
        mem[15] = enc(1,6,5);
        mem[16] = enc(7,0,1);
        mem[17] = enc(2,5,1);
        mem[18] = enc(31,7,7);
        mem[19] = enc(0,7,7);
        mem[20] = enc(7,0,1);
        mem[21] = enc(2,7,1);
        mem[22] = enc(6,4,3); mem[23] = 16'h0040;
        mem[24] = enc(6,3,2); mem[25] = 16'h001E;
        mem[26] = enc(2,3,6);
        mem[30] = enc(7,0,1);
        mem[31] = enc(4,0,7); mem[32] = 16'h0055;
        mem[33] = enc(2,7,1);
        mem[34] = enc(4,0,0); mem[35] = 16'h8000;
        mem[36] = enc(6,0,4); mem[37] = 16'h0028;
        mem[38] = enc(2,3,6);
        mem[40] = enc(5,0,0); mem[41] = 16'h0032;
        mem[42] = enc(2,3,6);
        mem[50] = enc(7,0,1);
        mem[51] = enc(2,0,1);
        mem[52] = enc(5,0,0); mem[53] = 16'h0034;
        mem[16'h200] = 16'hBEEF;
    endtask

    task automatic load_copy();
        clear_mem();
        mem[0]  = 16'h2001; mem[1]  = 16'h0010;
        mem[2]  = 16'h2002; mem[3]  = 16'h0030;
        mem[4]  = 16'h2006; mem[5]  = 16'h002F;
        mem[6]  = 16'h080B;
        mem[7]  = 16'h101A;
        mem[8]  = 16'h300E; mem[9]  = 16'h0000;
        mem[10] = 16'h3801;
        mem[11] = 16'h3802;
        mem[12] = 16'h2800; mem[13] = 16'h0006;
        for (int i = 0; i < 32; i++) mem[16'h10 + i] = 16'hA500 + 16'(i);
    endtask

    bit done = 1'b0;

    initial begin
        #250000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got %h expected %h", 16'h0000, 16'h0001);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        load_prog1();
        reset_and_probe("R1");
        // R2: cycle after the fetch read makes no access
        @(negedge clk);
        check(!mem_valid, "R2", {15'b0, mem_valid}, 16'h0000);
        run(400);
        for (int k = 0; k < 9; k++)
            check(mem[EXP[k].addr[9:0]] == EXP[k].val, EXP_REQ[k],
                  mem[EXP[k].addr[9:0]], EXP[k].val);
        // R4: seven stores executed, each a single write cycle
        check(wcnt == 7, "R4", 16'(wcnt), 16'd7);

        // reset from a running core, then the block-copy loop
        load_copy();
        reset_and_probe("R1");
        run(1500);
        for (int i = 0; i < 32; i++)
            check(mem[16'h30 + i] == 16'hA500 + 16'(i), "R3/R4/R8 copy",
                  mem[16'h30 + i], 16'hA500 + 16'(i));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule